// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block buffers 36-bit words between two clock domains. A producer writes on its own clock and a consumer reads on another. The two clocks may be unrelated or may be the same net. Storage is a dual-port array whose depth is a power-of-two parameter (2048 by default; 4096 and 8192 are also intended settings). The write and read pointers cross between the domains in Gray code through two-stage synchronizers.

A static mode input picks how the read side behaves. With `fwft_i` low, the block is a classic FIFO: a word written into an empty buffer stays in storage until the consumer issues a read, and `rd_avail_o` means "storage is not empty". With `fwft_i` high, the oldest word is moved into the output register on its own. `rd_avail_o` then means "a valid word is on `rd_data_o`", and a read consumes that word. On the write side, `wr_room_o` means "not full" in standard mode and "ready for input" in fall-through mode. In fall-through mode the output register adds one word of capacity. The mode may only change while reset is held.

Top module: `dcf_top`

## Requirements
- R1: Every accepted word leaves on `rd_data_o` exactly once, unchanged and in write order. This holds with asynchronous clocks and with one shared clock, in both modes.
- R2: While `rst_ni` is low, `rd_avail_o` is 0, `wr_room_o` is 1 and `rd_data_o` is 0.
- R3: In standard mode (`fwft_i`=0), writing into an empty buffer leaves `rd_data_o` unchanged. `rd_avail_o` rises within four read-clock edges after the write edge.
- R4: In standard mode, a read-clock edge with `rd_en_i`=1 and `rd_avail_o`=1 loads the oldest stored word onto `rd_data_o` at that edge.
- R5: In fall-through mode (`fwft_i`=1), the first word written into an empty buffer appears on `rd_data_o` with `rd_avail_o`=1 within four read-clock edges after the write edge, with no read request.
- R6: In fall-through mode, a read with `rd_avail_o`=1 either replaces `rd_data_o` with the next word or drops `rd_avail_o` if nothing is stored. While no read is issued, `rd_avail_o` and `rd_data_o` hold.
- R7: In standard mode, `wr_room_o` falls at the write edge that makes DEPTH words resident, with no added delay.
- R8: In fall-through mode, DEPTH+1 words (storage plus the output register) are accepted before `wr_room_o` falls.
- R9: A write presented while `wr_room_o` is 0 is dropped. It is never delivered on the read side.
- R10: In standard mode, a read while `rd_avail_o` is 0 is ignored: `rd_data_o` holds and no later word is lost.
- R11: In standard mode, the read edge that takes the last stored word drops `rd_avail_o` at that same edge.
- R12: Once reads have freed space, `wr_room_o` returns to 1 within four write-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| fwft_i | input | 1 | Mode: 0 standard, 1 fall-through; change only in reset |
| wr_en_i | input | 1 | Write request, sampled on rising `wclk_i` |
| wr_data_i | input | DW (36) | Word to store |
| wr_room_o | output | 1 | 1 = not full (standard) / input ready (fall-through) |
| rd_en_i | input | 1 | Read request, sampled on rising `rclk_i` |
| rd_data_o | output | DW (36) | Output register |
| rd_avail_o | output | 1 | 1 = not empty (standard) / output valid (fall-through) |

## Verification
A corrupted pointer or a broken Gray conversion shows up at the ports as a wrong, repeated or extra word on `rd_data_o`. The scoreboard catches this on the very first read after the fault. A wrong full or empty comparison lets a write past capacity or a read past the last word, and the words drained afterwards then fail the ordering check. A stuck output-valid bit in fall-through mode either holds a stale word or drops one, which is visible at the next read-clock edge. Flags that rise too late or fall too early are caught by the checks placed on the exact edges that R7, R8 and R11 name.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DCF_DW = 36;

  typedef enum logic {
    DCF_STD  = 1'b0,
    DCF_FWFT = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// two-stage synchronizer for a Gray-coded pointer
module dcf_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_gptr.sv
// binary pointer with registered Gray copy, updated together
module dcf_gptr #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_nxt;

  assign bin_nxt = bin_o + PW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/dcf_ram.sv
// dual-clock array; read register doubles as the output stage
module dcf_ram #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_top.sv
module dcf_top
  import dcf_pkg::*;
#(
  parameter int unsigned DW    = DCF_DW,
  parameter int unsigned DEPTH = 2048  // power of two, >= 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_room_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_avail_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  dcf_mode_e     mode;
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] rd_gray_w, wr_gray_r;
  logic          full, mem_empty, wr_do, rd_take, out_vld;

  assign mode = dcf_mode_e'(fwft_i);

  // write domain
  dcf_gptr #(.PW(PW)) i_wptr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .inc_i (wr_do),
    .bin_o (wr_bin),
    .gray_o(wr_gray)
  );

  dcf_sync #(.W(PW)) i_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_gray),
    .q_o   (rd_gray_w)
  );

  // full: Gray pointers differ in the two MSBs only
  assign full      = (wr_gray == {~rd_gray_w[PW-1 -: 2], rd_gray_w[PW-3:0]});
  assign wr_do     = wr_en_i && !full;
  assign wr_room_o = !full;

  // read domain
  dcf_gptr #(.PW(PW)) i_rptr (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .inc_i (rd_take),
    .bin_o (rd_bin),
    .gray_o(rd_gray)
  );

  dcf_sync #(.W(PW)) i_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_r)
  );

  assign mem_empty = (rd_gray == wr_gray_r);

  always_comb begin
    if (mode == DCF_FWFT) rd_take = !mem_empty && (!out_vld || rd_en_i);
    else                  rd_take = rd_en_i && !mem_empty;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)                out_vld <= 1'b0;
    else if (mode != DCF_FWFT)  out_vld <= 1'b0;
    else if (rd_take)           out_vld <= 1'b1;
    else if (rd_en_i)           out_vld <= 1'b0;
  end

  assign rd_avail_o = (mode == DCF_FWFT) ? out_vld : !mem_empty;

  dcf_ram #(.DW(DW), .AW(AW)) i_ram (
    .wclk_i (wclk_i),
    .we_i   (wr_do),
    .waddr_i(wr_bin[AW-1:0]),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rd_take),
    .raddr_i(rd_bin[AW-1:0]),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int unsigned DW = 36,
  parameter int unsigned PW = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          wr_en_i,
  input logic          wr_room_o,
  input logic          rd_en_i,
  input logic          rd_avail_o,
  input logic [DW-1:0] rd_data_o,
  input logic [PW-1:0] wr_ptr_i,
  input logic [PW-1:0] rd_ptr_i
);
  AST_WR_DROPPED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_room_o) |=> $stable(wr_ptr_i));  // R9

  AST_WR_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && wr_room_o) |=> (wr_ptr_i == $past(wr_ptr_i) + 1'b1));  // R1

  AST_RD_IGNORED: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && rd_en_i && !rd_avail_o) |=> ($stable(rd_ptr_i) && $stable(rd_data_o)));  // R10

  AST_STD_NO_FALL: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !rd_en_i) |=> $stable(rd_data_o));  // R3

  AST_FWFT_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_i && rd_avail_o && !rd_en_i) |=> (rd_avail_o && $stable(rd_data_o)));  // R6
endmodule

bind dcf_top dcf_chk #(.DW(DW), .PW(PW)) i_dcf_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .fwft_i    (fwft_i),
  .wr_en_i   (wr_en_i),
  .wr_room_o (wr_room_o),
  .rd_en_i   (rd_en_i),
  .rd_avail_o(rd_avail_o),
  .rd_data_o (rd_data_o),
  .wr_ptr_i  (wr_bin),
  .rd_ptr_i  (rd_bin)
);

// File: tb/test_dcf_top.sv
module test_dcf_top;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW          = 36;
  localparam int DEPTH       = 16;

  logic          wclk = 1'b0, rclk_free = 1'b0, rclk;
  logic          rst_n = 1'b0, fwft = 1'b0, same_clk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_room, rd_avail;
  logic          drain = 1'b0, poke = 1'b0, pend = 1'b0;
  logic [DW-1:0] exp_q[$];
  int            n_chk = 0, n_fail = 0;

  always #(WCLK_PERIOD / 2) wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk_free = ~rclk_free;
  assign rclk = same_clk ? wclk : rclk_free;

  dcf_top #(.DW(DW), .DEPTH(DEPTH)) i_dcf_top (
    .wclk_i    (wclk),
    .rclk_i    (rclk),
    .rst_ni    (rst_n),
    .fwft_i    (fwft),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .wr_room_o (wr_room),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .rd_avail_o(rd_avail)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [DW-1:0] got);
    logic [DW-1:0] want;
    if (exp_q.size() == 0) chk(1'b0, "R1/R9 unexpected word", got, '0);
    else begin
      want = exp_q.pop_front();
      chk(got == want, "R1 order", got, want);
    end
  endtask

  // driver: flag seen at the negedge holds until the write edge
  task automatic write_burst(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = base + DW'(i);
      if (wr_room) exp_q.push_back(base + DW'(i));
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  // monitor
  always @(negedge rclk) begin
    if (!rst_n) begin
      rd_en = 1'b0;
      pend  = 1'b0;
    end else if (!drain) begin
      rd_en = poke;
      pend  = 1'b0;
    end else if (!fwft) begin
      if (pend) pop_cmp(rd_data);
      pend  = rd_avail;
      rd_en = rd_avail;
    end else begin
      if (rd_avail) pop_cmp(rd_data);
      rd_en = rd_avail;
    end
  end

  task automatic do_reset(input logic mode, input logic same);
    rst_n = 1'b0;
    fwft = mode;
    same_clk = same;
    drain = 1'b0;
    poke = 1'b0;
    wr_en = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge wclk);
    chk(rd_avail == 1'b0, "R2 rd_avail in reset", DW'(rd_avail), '0);
    chk(wr_room == 1'b1, "R2 wr_room in reset", DW'(wr_room), 1);
    chk(rd_data == '0, "R2 rd_data in reset", rd_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge wclk);
  endtask

  task automatic drain_all();
    drain = 1'b1;
    repeat (DEPTH * 4 + 20) @(negedge rclk);
    drain = 1'b0;
    repeat (2) @(negedge rclk);
    chk(exp_q.size() == 0, "R1 all words delivered", DW'(exp_q.size()), '0);
    chk(rd_avail == 1'b0, "R6/R11 flag low after drain", DW'(rd_avail), '0);
    repeat (5) @(negedge wclk);
    chk(wr_room == 1'b1, "R12 room back after drain", DW'(wr_room), 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w;
    // standard mode, asynchronous clocks
    do_reset(1'b0, 1'b0);
    write_burst(1, 36'h100);
    repeat (5) @(negedge rclk);
    chk(rd_avail == 1'b1, "R3 flag after write", DW'(rd_avail), 1);
    chk(rd_data == '0, "R3 no fall-through", rd_data, '0);
    @(posedge rclk); poke = 1'b1;
    @(posedge rclk); poke = 1'b0;
    @(negedge rclk);
    w = exp_q.pop_front();
    chk(rd_data == w, "R4 read loads word", rd_data, w);
    chk(rd_avail == 1'b0, "R11 flag drops on last read", DW'(rd_avail), '0);
    @(posedge rclk); poke = 1'b1;
    repeat (3) @(posedge rclk);
    poke = 1'b0;
    repeat (2) @(negedge rclk);
    chk(rd_data == 36'h100, "R10 empty read holds data", rd_data, 36'h100);
    chk(rd_avail == 1'b0, "R10 still empty", DW'(rd_avail), '0);
    repeat (4) @(negedge wclk);
    write_burst(DEPTH - 1, 36'h200);
    chk(wr_room == 1'b1, "R7 room before last slot", DW'(wr_room), 1);
    write_burst(1, 36'h2ff);
    chk(wr_room == 1'b0, "R7 full at DEPTH words", DW'(wr_room), '0);
    write_burst(2, 36'h300);
    chk(exp_q.size() == DEPTH, "R9 count accepted", DW'(exp_q.size()), DEPTH);
    drain_all();

    // fall-through mode, asynchronous clocks
    do_reset(1'b1, 1'b0);
    write_burst(1, 36'h400);
    repeat (5) @(negedge rclk);
    chk(rd_avail == 1'b1, "R5 ready without read", DW'(rd_avail), 1);
    chk(rd_data == 36'h400, "R5 word falls through", rd_data, 36'h400);
    repeat (6) @(negedge wclk);
    write_burst(DEPTH - 1, 36'h500);
    chk(wr_room == 1'b1, "R8 room before DEPTH+1", DW'(wr_room), 1);
    write_burst(1, 36'h5ff);
    chk(wr_room == 1'b0, "R8 full at DEPTH+1", DW'(wr_room), '0);
    write_burst(1, 36'h600);
    chk(exp_q.size() == DEPTH + 1, "R8 count accepted", DW'(exp_q.size()), DEPTH + 1);
    drain_all();

    // standard mode, shared clock, concurrent traffic
    do_reset(1'b0, 1'b1);
    drain = 1'b1;
    write_burst(3 * DEPTH, 36'h700);
    drain_all();

    // fall-through mode, shared clock, concurrent traffic
    do_reset(1'b1, 1'b1);
    drain = 1'b1;
    write_burst(3 * DEPTH, 36'h900);
    drain_all();

    finish_run();
  end
endmodule